// File: doc/BRIEF.md
# Stepper Driver Fault Status Encoder

This block gathers the fault events of a two-winding stepper driver and reduces them to the two error bits that go back to the host in every serial reply. The analog front end supplies single-cycle event pulses for each bridge: a sink overcurrent shortly after turn-on (short to supply), a source overcurrent (short to ground), a flyback pulse, a change of winding polarity and a normal trip of the chopper comparator. It also supplies two thermal levels, pre-alarm and shutdown. The block keeps one flag per fault and bridge, applies the clear rules of each flag, and merges everything into a single two-bit code that ranks the faults by severity.

Open load is found from a missing flyback pulse after a polarity reversal. A settling filter counts the first chopping or polarity events after power-up, and until it has settled every checked reversal reports an open winding. No check is made in hold-current mode. The code is captured when a frame starts, so it stays fixed while it is shifted out, and thermal shutdown replaces the echoed operating bits with ones and turns the outputs off.

Top module: `diag_flag_encoder`

## Requirements
- R1: The status is coded as {error1, error2} on `status_bits[1:0]`: 2'b11 means no fault, 2'b01 means short to supply or open load, 2'b10 means short to ground, 2'b00 means thermal alarm. `status_bits` is loaded with the live code on a clock edge where `frame_start` is high and does not change on any other edge.
- R2: A `short_evt` pulse sets the short-to-supply flag of its bridge. The flag stays set across frames until a `chop_evt` pulse on the same bridge arrives without a `short_evt` in that cycle.
- R3: An `ovl_evt` pulse sets the source-overload flag of its bridge. The flag stays set until a `frame_end` pulse arrives without an `ovl_evt` in that cycle.
- R4: The severity order is thermal above short to ground above the lowest class (open load and short to supply). A higher class replaces a lower one. Codes within one class are combined by bitwise AND across the bridges.
- R5: Once the filter has settled, a polarity change outside hold mode opens a window of `FLY_WIN` cycles. A `flyback_evt` inside the window clears the open flag of that bridge. If the window ends without one, the open flag is set.
- R6: A polarity change while `hold_mode` is high evaluates nothing, cancels any open window and leaves the open flag unchanged.
- R7: Each bridge's filter counts `chop_evt` and `pol_chg` cycles up to `FILT_PULSES`. A polarity change outside hold mode that arrives while the count is still below `FILT_PULSES` sets the open flag at once. Chopping alone can settle the filter.
- R8: While `shutdown` is high, `op_bits_out` is all ones and `dev_off` is high. Otherwise `op_bits_out` echoes `op_bits_in`. A thermal pre-alarm leaves the echo untouched.
- R9: While `en_n` is high (standby), every flag, filter count, window and the status register are cleared on each clock edge, so the status reads 2'b11.
- R10: A synchronous active-low `rst_n` clears the same state, leaving `status_bits` at 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Device enable, low active; high puts the block in standby |
| frame_start | input | 1 | One-cycle pulse at the start of a serial frame |
| frame_end | input | 1 | One-cycle pulse at the end of a serial frame |
| short_evt | input | NB | Per bridge: sink overcurrent just after turn-on |
| chop_evt | input | NB | Per bridge: normal chopper comparator trip |
| ovl_evt | input | NB | Per bridge: source transistor overload |
| flyback_evt | input | NB | Per bridge: flyback pulse seen |
| pol_chg | input | NB | Per bridge: winding polarity reversed |
| hold_mode | input | NB | Per bridge: hold-current code selected |
| pre_alarm | input | 1 | Thermal pre-alarm level |
| shutdown | input | 1 | Thermal shutdown level |
| op_bits_in | input | OP_W | Operating bits to echo |
| op_bits_out | output | OP_W | Echoed operating bits, forced high on shutdown |
| dev_off | output | 1 | Turns the bridges off on thermal shutdown |
| status_bits | output | 2 | {error1, error2} captured at frame start |

## Verification
The assertions assume that each event input is a single-cycle pulse from a synchronised source. They also assume that `frame_start` and `frame_end` never fall in the same cycle and that the thermal inputs are levels that change only between frames. The stimulus drives every pulse for exactly one clock, keeps the frame boundaries apart, and switches `hold_mode` and the thermal levels only while no window or frame is in progress. A behavioural model in the bench follows each flag, filter count and window, and is compared with the outputs on every clock. Directed frames check each requirement against literal codes.

// File: rtl/diag_pkg.sv
// Package: status code type and the four code values shared by the
// encoder and its users. Assumes {error1, error2} ordering.
package diag_pkg;
    typedef logic [1:0] err_code_t;
    localparam err_code_t CODE_OK  = 2'b11;
    localparam err_code_t CODE_LOW = 2'b01;
    localparam err_code_t CODE_GND = 2'b10;
    localparam err_code_t CODE_HOT = 2'b00;
endpackage

// File: rtl/diag_open_load.sv
// Open-winding detector for one bridge. A polarity change outside hold
// mode either flags open at once (filter not settled) or opens a window
// in which a flyback pulse must appear. Assumes single-cycle event pulses.
module diag_open_load #(
    parameter int FILT_PULSES = 4,
    parameter int FLY_WIN     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic pol_chg,
    input  logic chop_evt,
    input  logic flyback,
    input  logic hold_mode,
    output logic open_flag
);
    localparam int CW = $clog2(FILT_PULSES + 1);
    localparam int WW = $clog2(FLY_WIN + 1);
    localparam logic [CW-1:0] FILT_MAX = CW'(FILT_PULSES);
    localparam logic [WW-1:0] WIN_LEN  = WW'(FLY_WIN);

    logic [CW-1:0] settle_cnt;
    logic [WW-1:0] win_cnt;
    logic          settled;

    assign settled = (settle_cnt == FILT_MAX);

    // Purpose: saturating settle counter advanced by chopping or polarity events.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            settle_cnt <= '0;
        end else if ((pol_chg || chop_evt) && !settled) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    // Purpose: flyback window and open flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            win_cnt   <= '0;
            open_flag <= 1'b0;
        end else if (pol_chg) begin
            if (hold_mode) begin
                win_cnt <= '0;
            end else if (!settled) begin
                win_cnt   <= '0;
                open_flag <= 1'b1;
            end else begin
                win_cnt <= WIN_LEN;
            end
        end else if (win_cnt != '0) begin
            if (flyback) begin
                open_flag <= 1'b0;
                win_cnt   <= '0;
            end else if (win_cnt == WW'(1)) begin
                open_flag <= 1'b1;
                win_cnt   <= '0;
            end else begin
                win_cnt <= win_cnt - 1'b1;
            end
        end
    end

    // R5: a flyback inside an open window clears the flag.
    assert_flyback_clears_R5: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (win_cnt != '0 && !pol_chg && flyback) |=> !open_flag);

    // R6: a hold-mode polarity change leaves the flag alone.
    assert_hold_no_eval_R6: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (pol_chg && hold_mode) |=> $stable(open_flag));

    // R7: an unsettled polarity change outside hold flags open.
    assert_unsettled_open_R7: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (pol_chg && !hold_mode && !settled) |=> open_flag);
endmodule

// File: rtl/diag_fault_latch.sv
// Sticky short-to-supply and source-overload flags of one bridge.
// Short clears on a normal chopper trip, overload on frame end.
// Assumes a set event in the same cycle as its clear wins.
module diag_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic short_evt,
    input  logic chop_evt,
    input  logic ovl_evt,
    input  logic frame_end,
    output logic short_flag,
    output logic ovl_flag
);
    // Purpose: short-to-supply flag, overwritten by a normal chop.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            short_flag <= 1'b0;
        end else if (short_evt) begin
            short_flag <= 1'b1;
        end else if (chop_evt) begin
            short_flag <= 1'b0;
        end
    end

    // Purpose: source-overload flag, cleared when a frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ovl_flag <= 1'b0;
        end else if (ovl_evt) begin
            ovl_flag <= 1'b1;
        end else if (frame_end) begin
            ovl_flag <= 1'b0;
        end
    end

    assert_short_sets_R2: assert property (@(posedge clk) disable iff (!rst_n || standby)
        short_evt |=> short_flag);

    assert_short_holds_R2: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (short_flag && !chop_evt) |=> short_flag);

    assert_ovl_clear_R3: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (frame_end && !ovl_evt) |=> !ovl_flag);
endmodule

// File: rtl/diag_encoder.sv
// Merges per-bridge fault flags into one status code by severity class,
// AND-combining within a class, and captures it at frame start.
// Assumes thermal inputs are levels.
module diag_encoder
    import diag_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic [NB-1:0] low_fault,
    input  logic [NB-1:0] gnd_fault,
    input  logic          pre_alarm,
    input  logic          shutdown,
    input  logic          frame_start,
    output err_code_t     status
);
    err_code_t low_code, gnd_code, live_code;

    // Purpose: AND-fold each class across bridges, then rank classes.
    always_comb begin
        low_code = CODE_OK;
        gnd_code = CODE_OK;
        for (int b = 0; b < NB; b++) begin
            low_code = low_code & (low_fault[b] ? CODE_LOW : CODE_OK);
            gnd_code = gnd_code & (gnd_fault[b] ? CODE_GND : CODE_OK);
        end
        if (pre_alarm || shutdown) begin
            live_code = CODE_HOT;
        end else if (gnd_code != CODE_OK) begin
            live_code = gnd_code;
        end else begin
            live_code = low_code;
        end
    end

    // Purpose: hold the code stable for the frame being shifted out.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            status <= CODE_OK;
        end else if (frame_start) begin
            status <= live_code;
        end
    end

    assert_status_stable_R1: assert property (@(posedge clk) disable iff (!rst_n || standby)
        !frame_start |=> $stable(status));

    assert_thermal_wins_R4: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (frame_start && (pre_alarm || shutdown)) |=> (status == CODE_HOT));

    assert_gnd_over_low_R4: assert property (@(posedge clk) disable iff (!rst_n || standby)
        (frame_start && !pre_alarm && !shutdown && (gnd_fault != '0)) |=> (status == CODE_GND));
endmodule

// File: rtl/diag_flag_encoder.sv
// Top: per-bridge fault latches and open-load detectors, the severity
// encoder, and the thermal override of the echoed operating bits.
// Assumes all event inputs are synchronous single-cycle pulses.
module diag_flag_encoder #(
    parameter int NB          = 2,
    parameter int OP_W        = 6,
    parameter int FILT_PULSES = 4,
    parameter int FLY_WIN     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_n,
    input  logic            frame_start,
    input  logic            frame_end,
    input  logic [NB-1:0]   short_evt,
    input  logic [NB-1:0]   chop_evt,
    input  logic [NB-1:0]   ovl_evt,
    input  logic [NB-1:0]   flyback_evt,
    input  logic [NB-1:0]   pol_chg,
    input  logic [NB-1:0]   hold_mode,
    input  logic            pre_alarm,
    input  logic            shutdown,
    input  logic [OP_W-1:0] op_bits_in,
    output logic [OP_W-1:0] op_bits_out,
    output logic            dev_off,
    output logic [1:0]      status_bits
);
    logic [NB-1:0] short_flag, ovl_flag, open_flag, low_fault;

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        diag_fault_latch u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .standby    (en_n),
            .short_evt  (short_evt[b]),
            .chop_evt   (chop_evt[b]),
            .ovl_evt    (ovl_evt[b]),
            .frame_end  (frame_end),
            .short_flag (short_flag[b]),
            .ovl_flag   (ovl_flag[b])
        );

        diag_open_load #(
            .FILT_PULSES (FILT_PULSES),
            .FLY_WIN     (FLY_WIN)
        ) u_open (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby   (en_n),
            .pol_chg   (pol_chg[b]),
            .chop_evt  (chop_evt[b]),
            .flyback   (flyback_evt[b]),
            .hold_mode (hold_mode[b]),
            .open_flag (open_flag[b])
        );

        assign low_fault[b] = short_flag[b] | open_flag[b];
    end

    diag_encoder #(.NB(NB)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (en_n),
        .low_fault   (low_fault),
        .gnd_fault   (ovl_flag),
        .pre_alarm   (pre_alarm),
        .shutdown    (shutdown),
        .frame_start (frame_start),
        .status      (status_bits)
    );

    // Purpose: thermal shutdown forces the echo high and turns the device off.
    always_comb begin
        op_bits_out = shutdown ? {OP_W{1'b1}} : op_bits_in;
        dev_off     = shutdown;
    end

    assert_standby_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (status_bits == 2'b11));

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (status_bits == 2'b11));

    assert_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_alarm && !shutdown) |-> (op_bits_out == op_bits_in && !dev_off));
endmodule

// File: tb/diag_flag_encoder_tb.sv
module diag_flag_encoder_tb;
    localparam int NB = 2, OP_W = 6, FILT = 4, WIN = 8;

    logic clk = 1'b0;
    logic rst_n, en_n, frame_start, frame_end, pre_alarm, shutdown;
    logic [NB-1:0] short_evt, chop_evt, ovl_evt, flyback_evt, pol_chg, hold_mode;
    logic [OP_W-1:0] op_bits_in, op_bits_out;
    logic dev_off;
    logic [1:0] status_bits;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    diag_flag_encoder #(.NB(NB), .OP_W(OP_W), .FILT_PULSES(FILT), .FLY_WIN(WIN)) u_dut (.*);

    // Behavioural reference model
    int m_settle[NB], m_win[NB];
    bit m_open[NB], m_short[NB], m_ovl[NB];
    bit [1:0] m_status = 2'b11;

    function automatic bit [1:0] model_live();
        bit anylow = 0, anygnd = 0;
        for (int b = 0; b < NB; b++) begin
            if (m_open[b] || m_short[b]) anylow = 1;
            if (m_ovl[b]) anygnd = 1;
        end
        if (pre_alarm || shutdown) return 2'b00;
        if (anygnd) return 2'b10;
        if (anylow) return 2'b01;
        return 2'b11;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || en_n) begin
            m_status = 2'b11;
            for (int b = 0; b < NB; b++) begin
                m_settle[b] = 0; m_win[b] = 0; m_open[b] = 0; m_short[b] = 0; m_ovl[b] = 0;
            end
        end else begin
            if (frame_start) m_status = model_live();
            for (int b = 0; b < NB; b++) begin
                if (short_evt[b]) m_short[b] = 1; else if (chop_evt[b]) m_short[b] = 0;
                if (ovl_evt[b]) m_ovl[b] = 1; else if (frame_end) m_ovl[b] = 0;
                if (pol_chg[b]) begin
                    if (hold_mode[b]) m_win[b] = 0;
                    else if (m_settle[b] < FILT) begin m_win[b] = 0; m_open[b] = 1; end
                    else m_win[b] = WIN;
                end else if (m_win[b] > 0) begin
                    if (flyback_evt[b]) begin m_open[b] = 0; m_win[b] = 0; end
                    else if (m_win[b] == 1) begin m_open[b] = 1; m_win[b] = 0; end
                    else m_win[b] = m_win[b] - 1;
                end
                if ((pol_chg[b] || chop_evt[b]) && m_settle[b] < FILT) m_settle[b]++;
            end
        end
    end

    // Per-cycle comparison with the model, away from the edge (R1, R8)
    always @(posedge clk) begin
        #1;
        if (!done) begin
            n_chk++;
            if (status_bits !== m_status) begin
                n_fail++;
                $display("FAIL R1 model: status got %b expected %b at %0t", status_bits, m_status, $time);
            end
            n_chk++;
            if (op_bits_out !== (shutdown ? 6'h3F : op_bits_in) || dev_off !== shutdown) begin
                n_fail++;
                $display("FAIL R8 model: op %h/%b expected %h/%b", op_bits_out, dev_off,
                         shutdown ? 6'h3F : op_bits_in, shutdown);
            end
        end
    end

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic [NB-1:0] sig, input int b);
        sig[b] = 1'b1; tick(); sig[b] = 1'b0;
    endtask

    task automatic fstart();
        frame_start = 1'b1; tick(); frame_start = 1'b0; tick();
    endtask

    task automatic fend();
        frame_end = 1'b1; tick(); frame_end = 1'b0; tick();
    endtask

    task automatic standby_cycle();
        en_n = 1'b1; tick(2); en_n = 1'b0; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; en_n = 0; frame_start = 0; frame_end = 0; pre_alarm = 0; shutdown = 0;
        short_evt = 0; chop_evt = 0; ovl_evt = 0; flyback_evt = 0; pol_chg = 0; hold_mode = 0;
        op_bits_in = 6'h2A;
        tick(3);
        check("R10 reset status", {6'd0, status_bits}, 8'h03);
        rst_n = 1; tick();
        fstart();
        check("R1 idle frame normal", {6'd0, status_bits}, 8'h03);

        // R2 short to supply
        pulse(short_evt, 0); tick();
        check("R1 status held before frame", {6'd0, status_bits}, 8'h03);
        fstart();
        check("R2 short sets 01", {6'd0, status_bits}, 8'h01);
        fend(); fstart();
        check("R2 short persists over frames", {6'd0, status_bits}, 8'h01);
        pulse(chop_evt, 0); fstart();
        check("R2 chop clears short", {6'd0, status_bits}, 8'h03);

        // R3 source overload
        pulse(ovl_evt, 1); fstart();
        check("R3 overload 10", {6'd0, status_bits}, 8'h02);
        fstart();
        check("R3 overload held until frame end", {6'd0, status_bits}, 8'h02);
        fend(); fstart();
        check("R3 frame end clears", {6'd0, status_bits}, 8'h03);

        // R4 dominance
        pulse(short_evt, 0); pulse(ovl_evt, 1); fstart();
        check("R4 ground over supply", {6'd0, status_bits}, 8'h02);
        fend(); fstart();
        check("R4 lower class returns", {6'd0, status_bits}, 8'h01);
        pre_alarm = 1; tick(); fstart();
        check("R4 prealarm 00", {6'd0, status_bits}, 8'h00);
        check("R8 prealarm echo", {2'd0, op_bits_out}, 8'h2A);
        pre_alarm = 0; tick();

        // R8 shutdown
        shutdown = 1; tick();
        check("R8 shutdown forces ones", {2'd0, op_bits_out}, 8'h3F);
        check("R8 dev_off", {7'd0, dev_off}, 8'h01);
        fstart();
        check("R8 shutdown status 00", {6'd0, status_bits}, 8'h00);
        shutdown = 0; tick();
        check("R8 echo resumes", {2'd0, op_bits_out}, 8'h2A);

        // R9 standby clears
        standby_cycle(); fstart();
        check("R9 standby clears flags", {6'd0, status_bits}, 8'h03);

        // R7 unsettled filter flags open
        pulse(pol_chg, 1); tick(2); pulse(flyback_evt, 1); fstart();
        check("R7 early open flagged", {6'd0, status_bits}, 8'h01);
        for (int k = 0; k < 3; k++) begin
            pulse(pol_chg, 1); tick(2); pulse(flyback_evt, 1); tick();
        end
        pulse(pol_chg, 1); tick(2); pulse(flyback_evt, 1); fstart();
        check("R5 settled flyback clears open", {6'd0, status_bits}, 8'h03);

        // R5 missing flyback
        pulse(pol_chg, 1); tick(WIN + 2); fstart();
        check("R5 missing flyback open", {6'd0, status_bits}, 8'h01);
        pulse(pol_chg, 1); tick(3); pulse(flyback_evt, 1); fstart();
        check("R5 flyback returns normal", {6'd0, status_bits}, 8'h03);

        // R6 hold mode
        hold_mode[1] = 1; tick();
        pulse(pol_chg, 1); tick(WIN + 2); fstart();
        check("R6 hold no open check", {6'd0, status_bits}, 8'h03);
        hold_mode[1] = 0; tick();

        // R7 chopping settles filter
        standby_cycle();
        for (int k = 0; k < FILT; k++) begin pulse(chop_evt, 0); tick(); end
        pulse(pol_chg, 0); tick(2); pulse(flyback_evt, 0); fstart();
        check("R7 chop settles filter", {6'd0, status_bits}, 8'h03);

        tick(3);
        finish_run();
    end
endmodule